// File: doc/BRIEF.md
# Direct-Compare Matcher for SEC-DED Protected Tags

This block decides whether a 4-bit lookup tag is the value held in an 8-bit stored word protected by an (8,4) single-error-correcting, double-error-detecting code. It never decodes the stored word. It encodes the incoming tag instead, producing four check bits. Because the code is systematic, the data comparison runs at the same time as that encoding. Two XOR banks form the difference vectors for the data field and for the check field. Half-adder weight accumulators, wired as a butterfly, and small OR trees turn those vectors into a coarse Hamming distance with three outcomes: at most 1, exactly 2, and 3 or more.

A decision stage maps that distance onto a one-hot verdict. The verdict is a hit when the stored word is the tag's codeword with at most one flipped bit. It is a fault when the distance is exactly two, which is a detected but uncorrectable error. It is a miss otherwise. Typical uses are tag-array or translation-buffer lookups, where the decoder would otherwise sit on the critical path. A parameter chooses a registered verdict, with one cycle of latency and reset to all-low, or a purely combinational verdict. The stored word is never repaired.

Top module: `dcm_top`

## Requirements
- R1: Stored word layout: bits [3:0] hold the tag bits t0..t3 (bit i = ti). Bits [7:4] are check bits c4..c7 with c4 = t0^t1^t3, c5 = t0^t2^t3, c6 = t1^t2^t3, c7 = t0^t1^t2. The matcher encodes the incoming tag with these equations.
- R2: The distance is the number of 1s in (encoded tag XOR stored word), counting both fields, and it is formed without decoding the stored word. Each 4-bit field accumulator reports weight-4 only when all four of its inputs differ.
- R3: Distance 0 gives the hit verdict.
- R4: Distance 1 gives the hit verdict, whether the differing bit lies in the data field or in the check field.
- R5: Distance exactly 2 gives the fault verdict, whatever way the two bits are split across the fields.
- R6: Distance 3 or more gives the miss verdict. A stored word that differs from the incoming tag in three or more data bits is always a miss.
- R7: While reset is active, all three verdict outputs are low. In every later cycle exactly one of them is high.
- R8: With the default REG_OUT = 1, the verdict for inputs sampled at a rising clock edge appears at the outputs right after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered verdict |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_i | input | 4 | Incoming tag to look up |
| code_i | input | 8 | Stored protected word (data in [3:0], check bits in [7:4]) |
| match_o | output | 1 | Hit: stored word is the tag's codeword within one bit |
| fault_o | output | 1 | Detected uncorrectable error: distance exactly two |
| mismatch_o | output | 1 | Miss: distance three or more |

## Verification
The bench sweeps every tag against every possible stored word. The distance boundaries therefore all get hit, including 1-to-2 and 2-to-3, with the differing bits placed in the data field, in the check field, or split across both. A design that dropped the carry between the two field accumulators would call a 1+1 split a hit instead of a fault. One that saturated a field at two would call a 3-bit data difference a fault instead of a miss. A wrong check-bit equation shows up as a miss on an intact codeword. Resets applied in the middle of the run confirm that the verdicts go all-low and then come back one-hot, with the one-cycle latency intact.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int TAG_W  = 4;
  localparam int PAR_W  = 4;
  localparam int CW_W   = TAG_W + PAR_W;
  localparam int PAIRS  = TAG_W / 2;

  // Per-field or combined weight summary: ge4 means at least four ones.
  typedef struct packed {
    logic ge4;
    logic w2;
    logic w1;
  } weight_t;

  typedef enum logic [1:0] {
    VD_HIT   = 2'd0,
    VD_FAULT = 2'd1,
    VD_MISS  = 2'd2
  } verdict_e;

  // Extended Hamming check bits for a 4-bit tag.
  function automatic logic [PAR_W-1:0] chk_bits(input logic [TAG_W-1:0] d);
    logic [PAR_W-1:0] p;
    p[0] = d[0] ^ d[1] ^ d[3];
    p[1] = d[0] ^ d[2] ^ d[3];
    p[2] = d[1] ^ d[2] ^ d[3];
    p[3] = d[0] ^ d[1] ^ d[2];
    return p;
  endfunction

  // Half adder: {carry, sum}.
  function automatic logic [1:0] half_add(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction
endpackage

// File: rtl/dcm_field_bwa.sv
module dcm_field_bwa
  import dcm_pkg::*;
(
  input  logic [TAG_W-1:0] diff_i,
  output weight_t          wt_o
);
  logic [PAIRS-1:0] s1_sum;
  logic [PAIRS-1:0] s1_car;

  // Stage one: pairwise half adders on raw difference bits.
  genvar gi;
  generate
    for (gi = 0; gi < PAIRS; gi++) begin : g_s1
      assign {s1_car[gi], s1_sum[gi]} = half_add(diff_i[2*gi+1], diff_i[2*gi]);
    end
  endgenerate

  // Stage two: sums meet sums, carries meet carries.
  logic sum_lo, sum_hi;
  logic car_lo, car_hi;
  assign {sum_hi, sum_lo} = half_add(s1_sum[0], s1_sum[1]);
  assign {car_hi, car_lo} = half_add(s1_car[0], s1_car[1]);

  // sum_hi and car_lo both carry weight 2 and cannot be set together.
  assign wt_o.w1  = sum_lo;
  assign wt_o.w2  = sum_hi | car_lo;
  assign wt_o.ge4 = car_hi;
endmodule

// File: rtl/dcm_merge.sv
module dcm_merge
  import dcm_pkg::*;
(
  input  weight_t data_wt_i,
  input  weight_t par_wt_i,
  output weight_t tot_wt_o
);
  logic w1_sum, w1_car;
  logic w2_sum, w2_car;
  logic w2b_sum, w2b_car;

  // Weight-1 accumulator.
  assign {w1_car, w1_sum} = half_add(data_wt_i.w1, par_wt_i.w1);
  // Weight-2 accumulator: field weight-2 bits plus the weight-1 carry.
  assign {w2_car, w2_sum}   = half_add(data_wt_i.w2, par_wt_i.w2);
  assign {w2b_car, w2b_sum} = half_add(w2_sum, w1_car);

  // Everything of weight four or more collapses into one OR tree.
  assign tot_wt_o.ge4 = (data_wt_i.ge4 | par_wt_i.ge4) | (w2_car | w2b_car);
  assign tot_wt_o.w2  = w2b_sum;
  assign tot_wt_o.w1  = w1_sum;
endmodule

// File: rtl/dcm_decide.sv
module dcm_decide
  import dcm_pkg::*;
(
  input  weight_t  wt_i,
  output verdict_e vd_o
);
  always_comb begin
    if (wt_i.ge4)                 vd_o = VD_MISS;
    else if (wt_i.w2 && wt_i.w1)  vd_o = VD_MISS;
    else if (wt_i.w2)             vd_o = VD_FAULT;
    else                          vd_o = VD_HIT;
  end
endmodule

// File: rtl/dcm_top.sv
module dcm_top
  import dcm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [CW_W-1:0]  code_i,
  output logic            match_o,
  output logic            fault_o,
  output logic            mismatch_o
);
  // Named internal events for the checker.
  logic [PAR_W-1:0] enc_par;
  logic [TAG_W-1:0] data_diff;
  logic [PAR_W-1:0] par_diff;
  weight_t          data_wt;
  weight_t          par_wt;
  weight_t          tot_wt;
  verdict_e         vd;
  logic [2:0]       vd_oh;

  // Encoding and data XOR run side by side.
  assign enc_par   = chk_bits(tag_i);
  assign data_diff = tag_i ^ code_i[TAG_W-1:0];
  assign par_diff  = enc_par ^ code_i[CW_W-1:TAG_W];

  dcm_field_bwa u_data_bwa (.diff_i(data_diff), .wt_o(data_wt));
  dcm_field_bwa u_par_bwa  (.diff_i(par_diff),  .wt_o(par_wt));
  dcm_merge     u_merge    (.data_wt_i(data_wt), .par_wt_i(par_wt), .tot_wt_o(tot_wt));
  dcm_decide    u_decide   (.wt_i(tot_wt), .vd_o(vd));

  assign vd_oh = {vd == VD_MISS, vd == VD_FAULT, vd == VD_HIT};

  generate
    if (REG_OUT) begin : g_reg
      logic [2:0] vd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= 3'b000;
        else        vd_q <= vd_oh;
      end
      assign {mismatch_o, fault_o, match_o} = vd_q;
    end else begin : g_comb
      assign {mismatch_o, fault_o, match_o} = rst_n ? vd_oh : 3'b000;
    end
  endgenerate
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker
  import dcm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAG_W-1:0] tag_i,
  input logic [CW_W-1:0]  code_i,
  input logic [PAR_W-1:0] enc_par,
  input logic [TAG_W-1:0] data_diff,
  input logic [2:0]       data_wt_bits,
  input logic             match_o,
  input logic             fault_o,
  input logic             mismatch_o
);
  logic primed;
  logic [CW_W-1:0]  seen_enc;
  logic [CW_W-1:0]  seen_code;
  logic [TAG_W-1:0] seen_ddiff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seen_enc   <= '0;
          seen_code  <= '0;
          seen_ddiff <= '0;
        end else begin
          seen_enc   <= {enc_par, tag_i};
          seen_code  <= code_i;
          seen_ddiff <= data_diff;
        end
      end
    end else begin : g_now
      assign seen_enc   = {enc_par, tag_i};
      assign seen_code  = code_i;
      assign seen_ddiff = data_diff;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!match_o && !fault_o && !mismatch_o); // R7
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> $countones({match_o, fault_o, mismatch_o}) == 1); // R7

  AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && seen_enc == seen_code) |-> match_o); // R3

  AST_FAR_DATA_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $countones(seen_ddiff) >= 3) |-> mismatch_o); // R6

  AST_FIELD_WEIGHT4: assert property (@(posedge clk) disable iff (!rst_n)
    data_wt_bits[2] |-> (data_wt_bits[1:0] == 2'b00 && data_diff == '1)); // R2
endmodule

bind dcm_top dcm_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tag_i(tag_i),
  .code_i(code_i),
  .enc_par(enc_par),
  .data_diff(data_diff),
  .data_wt_bits(data_wt),
  .match_o(match_o),
  .fault_o(fault_o),
  .mismatch_o(mismatch_o)
);

// File: tb/dcm_top_tb.sv
module dcm_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tag_i = '0;
  logic [7:0] code_i = '0;
  logic       match_o, fault_o, mismatch_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  dcm_top u_dut (.*);

  always #10 clk = ~clk;

  // Behavioural reference: codeword via column masks, distance via loop.
  function automatic logic [7:0] ref_encode(input logic [3:0] t);
    logic [3:0] msk [4];
    logic [7:0] w;
    msk[0] = 4'b1011; msk[1] = 4'b1101; msk[2] = 4'b1110; msk[3] = 4'b0111;
    w = {4'b0000, t};
    for (int j = 0; j < 4; j++) w[4+j] = ^(t & msk[j]);
    return w;
  endfunction

  function automatic int ref_dist(input logic [3:0] t, input logic [7:0] c);
    logic [7:0] x;
    int n;
    x = ref_encode(t) ^ c;
    n = 0;
    for (int b = 0; b < 8; b++) n += int'(x[b]);
    return n;
  endfunction

  // Expected {mismatch, fault, match} and the requirement it exercises.
  function automatic logic [2:0] ref_verdict(input int d);
    if (d <= 1) return 3'b001;
    if (d == 2) return 3'b010;
    return 3'b100;
  endfunction

  function automatic string req_of(input int d);
    if (d == 0) return "R3";
    if (d == 1) return "R4";
    if (d == 2) return "R5";
    return "R6";
  endfunction

  logic [2:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input logic [2:0] exp, input string req);
    n_cmp++;
    if ({mismatch_o, fault_o, match_o} !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (tag=%h code=%h)", req,
               {mismatch_o, fault_o, match_o}, exp, tag_i, code_i);
    end
  endtask

  // Drive at the falling edge, check the verdict one edge later (R8).
  task automatic apply(input logic [3:0] t, input logic [7:0] c, input string req);
    int d;
    d = ref_dist(t, c);
    tag_i  = t;
    code_i = c;
    exp_q.push_back(ref_verdict(d));
    tag_q.push_back(req.len() != 0 ? req : req_of(d));
    @(posedge clk);
    @(negedge clk);
    check(exp_q.pop_front(), {tag_q.pop_front(), "/R8"});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(3'b000, "R7 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: intact codewords hit; every other tag's codeword misses.
    for (int t = 0; t < 16; t++)
      apply(4'(t), ref_encode(4'(t)), "R1");
    for (int t = 0; t < 16; t++)
      apply(4'(t), ref_encode(4'((t + 5) % 16)), "R1");

    // R4/R5 targeted splits: single check-bit flip, 1+1 split, 2 in check field.
    apply(4'h9, ref_encode(4'h9) ^ 8'h40, "R4");
    apply(4'h9, ref_encode(4'h9) ^ 8'h11, "R5");
    apply(4'h6, ref_encode(4'h6) ^ 8'hA0, "R5");
    // R6: three data bits differ, three split bits, all eight flipped.
    apply(4'h3, ref_encode(4'h3) ^ 8'h07, "R6");
    apply(4'h3, ref_encode(4'h3) ^ 8'h83, "R6");
    apply(4'hC, ~ref_encode(4'hC), "R6");

    // Full sweep: every tag against every stored word (R2..R6, R7 one-hot).
    for (int t = 0; t < 16; t++)
      for (int c = 0; c < 256; c++) begin
        apply(4'(t), 8'(c), "");
        n_cmp++;
        if ($countones({mismatch_o, fault_o, match_o}) != 1) begin
          n_bad++;
          $display("FAIL R7: got %b expected one-hot", {mismatch_o, fault_o, match_o});
        end
      end

    // R7: reset mid-run clears verdicts, then operation resumes.
    rst_n = 1'b0;
    @(negedge clk);
    check(3'b000, "R7 mid reset");
    rst_n = 1'b1;
    apply(4'hA, ref_encode(4'hA), "R3");
    apply(4'hA, ref_encode(4'hA) ^ 8'h02, "R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule